// File: doc/BRIEF.md
# Receive/Transmit Digital Gain Stage

This block scales two independent signed sample streams. The receive stream can be amplified and the transmit stream can be attenuated, each in 3 dB steps, and either path can be silenced. Each path has a valid strobe and a fixed two-cycle pipeline. Results are rounded to the nearest integer and clamped to the sample width.

Two configuration registers set the gains. A coarse register holds one fixed-gain bit per path. A fine register holds a step code and a mute bit for each path. The fine register is consulted only while both coarse bits are clear. Each sample takes the setting that is in force in the cycle it enters, so a configuration change never splits a sample.

Top module: `rxtx_gain_stage`

## Requirements
- R1: While reset is asserted and after it is released, both output valids are low and both output samples are zero. Both configuration registers reset to zero, which gives unity gain and no mute.
- R2: A sample presented with its valid high appears on the same path's output, with the output valid high, exactly two clock cycles later. While the output valid is low, the output sample holds its previous value. The two paths are independent.
- R3: When both coarse bits are 0, fine bits [2:0] select the receive gain. Codes 0..4 give 0/3/6/9/12 dB, using Q2.14 multipliers 16384, 23143, 32690, 46176 and 65226. The output is (x*M + 8192) shifted right arithmetically by 14, then saturated.
- R4: When both coarse bits are 0, fine bits [6:4] select the transmit attenuation. Codes 0..4 give 0/3/6/9/12 dB of loss, using multipliers 16384, 11599, 8211, 5813 and 4115, with the same rounding. The transmit output magnitude never exceeds the input magnitude.
- R5: Step codes 5, 6 and 7 on either path give unity gain (multiplier 16384).
- R6: When both coarse bits are 0, fine bit 3 mutes the receive path and fine bit 7 mutes the transmit path. A muted path still raises its output valid and outputs exactly zero.
- R7: Coarse bit 0 applies +6 dB (multiplier 32690) to the receive path. Coarse bit 1 applies -3 dB (multiplier 11599) to the transmit path. While either coarse bit is set, every fine field, including both mute bits, is ignored, and a path whose coarse bit is clear runs at unity gain.
- R8: Results beyond the sample range clamp to +2^(DW-1)-1 or -2^(DW-1). They never wrap around.
- R9: A sample uses the register contents from before any write in the cycle the sample enters. A write takes effect from the next sample onward, and samples already in the pipeline are unaffected.
- R10: A coarse write strobe loads data bits [1:0] into the coarse register. A fine write strobe loads data bits [7:0] into the fine register. Both registers hold their values between writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| coarse_we | input | 1 | Coarse register write strobe |
| coarse_wdata | input | 2 | Coarse data: bit0 receive +6 dB, bit1 transmit -3 dB |
| fine_we | input | 1 | Fine register write strobe |
| fine_wdata | input | 8 | Fine data: [2:0] rx step, [3] rx mute, [6:4] tx step, [7] tx mute |
| rx_valid_i | input | 1 | Receive sample valid |
| rx_sample_i | input | DW | Receive sample, signed |
| tx_valid_i | input | 1 | Transmit sample valid |
| tx_sample_i | input | DW | Transmit sample, signed |
| rx_valid_o | output | 1 | Scaled receive sample valid |
| rx_sample_o | output | DW | Scaled receive sample, signed |
| tx_valid_o | output | 1 | Scaled transmit sample valid |
| tx_sample_o | output | DW | Scaled transmit sample, signed |

## Verification
The state inside this block is the two configuration registers and two pipeline stages per path. A wrong register bit shows up at the output two cycles after the next sample: a wrong multiplier, a wrong mute, or a fine field that should have been ignored but was not. A fault in the pipeline stages shows up within two cycles as a misplaced valid or a held sample that changes. The bench therefore compares every output on every cycle against a behavioural model. Sparse and back-to-back samples, with writes issued in the same cycle as samples, expose any setting that leaks across a sample boundary.

// File: rtl/rxtx_gain_stage.sv
module rxtx_gain_stage #(
  parameter int DW   = 16,
  parameter int FRAC = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 coarse_we,
  input  logic [1:0]           coarse_wdata,
  input  logic                 fine_we,
  input  logic [7:0]           fine_wdata,
  input  logic                 rx_valid_i,
  input  logic signed [DW-1:0] rx_sample_i,
  input  logic                 tx_valid_i,
  input  logic signed [DW-1:0] tx_sample_i,
  output logic                 rx_valid_o,
  output logic signed [DW-1:0] rx_sample_o,
  output logic                 tx_valid_o,
  output logic signed [DW-1:0] tx_sample_o
);
  localparam int  CW    = FRAC + 2;
  localparam int  PW    = DW + CW + 1;
  localparam real STEP  = 1.4125375446227544;
  localparam real SCALE = 2.0 ** FRAC;
  localparam logic [CW-1:0] UNITY = CW'(1) << FRAC;
  localparam logic [CW-1:0] G3  = CW'($rtoi(STEP * SCALE + 0.5));
  localparam logic [CW-1:0] G6  = CW'($rtoi(STEP * STEP * SCALE + 0.5));
  localparam logic [CW-1:0] G9  = CW'($rtoi(STEP * STEP * STEP * SCALE + 0.5));
  localparam logic [CW-1:0] G12 = CW'($rtoi(STEP * STEP * STEP * STEP * SCALE + 0.5));
  localparam logic [CW-1:0] A3  = CW'($rtoi(SCALE / STEP + 0.5));
  localparam logic [CW-1:0] A6  = CW'($rtoi(SCALE / (STEP * STEP) + 0.5));
  localparam logic [CW-1:0] A9  = CW'($rtoi(SCALE / (STEP * STEP * STEP) + 0.5));
  localparam logic [CW-1:0] A12 = CW'($rtoi(SCALE / (STEP * STEP * STEP * STEP) + 0.5));
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);

  logic [1:0] coarse_q;
  logic [7:0] fine_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_q <= '0;
      fine_q   <= '0;
    end else begin
      if (coarse_we) coarse_q <= coarse_wdata;
      if (fine_we)   fine_q   <= fine_wdata;
    end
  end

  function automatic logic [CW-1:0] boost(input logic [2:0] code);
    case (code)
      3'd1:    return G3;
      3'd2:    return G6;
      3'd3:    return G9;
      3'd4:    return G12;
      default: return UNITY;
    endcase
  endfunction

  function automatic logic [CW-1:0] cut(input logic [2:0] code);
    case (code)
      3'd1:    return A3;
      3'd2:    return A6;
      3'd3:    return A9;
      3'd4:    return A12;
      default: return UNITY;
    endcase
  endfunction

  logic [CW-1:0]        path_coef [2];
  logic                 path_mute [2];
  logic                 vin       [2];
  logic signed [DW-1:0] sin       [2];

  assign vin[0] = rx_valid_i;
  assign vin[1] = tx_valid_i;
  assign sin[0] = rx_sample_i;
  assign sin[1] = tx_sample_i;

  always_comb begin
    if (|coarse_q) begin
      path_coef[0] = coarse_q[0] ? G6 : UNITY;
      path_coef[1] = coarse_q[1] ? A3 : UNITY;
      path_mute[0] = 1'b0;
      path_mute[1] = 1'b0;
    end else begin
      path_coef[0] = boost(fine_q[2:0]);
      path_coef[1] = cut(fine_q[6:4]);
      path_mute[0] = fine_q[3];
      path_mute[1] = fine_q[7];
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_path
    logic                 v1_q, v2_q;
    logic signed [PW-1:0] prod_q;
    logic signed [DW-1:0] out_q;
    logic [CW-1:0]        k_eff;
    logic signed [PW-1:0] rnd;
    logic signed [DW-1:0] sat;
    logic                 fits;

    assign k_eff = path_mute[i] ? '0 : path_coef[i];
    assign rnd   = (prod_q + HALF) >>> FRAC;
    assign fits  = (&rnd[PW-1:DW-1]) || !(|rnd[PW-1:DW-1]);
    assign sat   = fits ? rnd[DW-1:0]
                 : (rnd[PW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}});

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v1_q   <= 1'b0;
        v2_q   <= 1'b0;
        prod_q <= '0;
        out_q  <= '0;
      end else begin
        v1_q <= vin[i];
        v2_q <= v1_q;
        if (vin[i]) prod_q <= PW'(sin[i]) * PW'($signed({1'b0, k_eff}));
        if (v1_q)   out_q  <= sat;
      end
    end
  end

  assign rx_valid_o  = g_path[0].v2_q;
  assign rx_sample_o = g_path[0].out_q;
  assign tx_valid_o  = g_path[1].v2_q;
  assign tx_sample_o = g_path[1].out_q;
endmodule

module rxtx_gain_stage_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rx_valid_i,
  input logic signed [DW-1:0] rx_sample_i,
  input logic                 tx_valid_i,
  input logic signed [DW-1:0] tx_sample_i,
  input logic                 rx_valid_o,
  input logic signed [DW-1:0] rx_sample_o,
  input logic                 tx_valid_o,
  input logic signed [DW-1:0] tx_sample_o,
  input logic                 rx_mute,
  input logic                 tx_mute
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  logic warm;
  assign warm = age >= 2'd2;

  function automatic int mag(input logic signed [DW-1:0] v);
    return (v < 0) ? -int'(v) : int'(v);
  endfunction

  assert_rx_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (rx_valid_o == $past(rx_valid_i, 2)));
  assert_tx_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (tx_valid_o == $past(tx_valid_i, 2)));
  assert_rx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_o |-> $stable(rx_sample_o));
  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid_o |-> $stable(tx_sample_o));
  assert_rx_mute_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && rx_valid_o && $past(rx_mute, 2)) |-> (rx_sample_o == '0));
  assert_tx_mute_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && tx_valid_o && $past(tx_mute, 2)) |-> (tx_sample_o == '0));
  assert_tx_no_growth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && tx_valid_o) |-> (mag(tx_sample_o) <= mag($past(tx_sample_i, 2))));
  assert_rx_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && rx_valid_o && !$past(rx_mute, 2) && ($past(rx_sample_i, 2) >= 0))
      |-> (rx_sample_o >= 0));
endmodule

bind rxtx_gain_stage rxtx_gain_stage_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rx_valid_i(rx_valid_i), .rx_sample_i(rx_sample_i),
  .tx_valid_i(tx_valid_i), .tx_sample_i(tx_sample_i),
  .rx_valid_o(rx_valid_o), .rx_sample_o(rx_sample_o),
  .tx_valid_o(tx_valid_o), .tx_sample_o(tx_sample_o),
  .rx_mute(path_mute[0]), .tx_mute(path_mute[1])
);

// File: tb/rxtx_gain_stage_bench.sv
`timescale 1ns/1ps
module rxtx_gain_stage_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coarse_we = 1'b0;
  logic [1:0] coarse_wdata = '0;
  logic fine_we = 1'b0;
  logic [7:0] fine_wdata = '0;
  logic rx_valid_i = 1'b0, tx_valid_i = 1'b0;
  logic signed [15:0] rx_sample_i = '0, tx_sample_i = '0;
  logic rx_valid_o, tx_valid_o;
  logic signed [15:0] rx_sample_o, tx_sample_o;

  always #4 clk = ~clk;

  rxtx_gain_stage u_rxtx_gain_stage (
    .clk(clk), .rst_n(rst_n),
    .coarse_we(coarse_we), .coarse_wdata(coarse_wdata),
    .fine_we(fine_we), .fine_wdata(fine_wdata),
    .rx_valid_i(rx_valid_i), .rx_sample_i(rx_sample_i),
    .tx_valid_i(tx_valid_i), .tx_sample_i(tx_sample_i),
    .rx_valid_o(rx_valid_o), .rx_sample_o(rx_sample_o),
    .tx_valid_o(tx_valid_o), .tx_sample_o(tx_sample_o)
  );

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit done = 0;

  // reference model state
  int m_coarse, m_fine;
  bit m_v1 [2];
  bit m_v2 [2];
  int m_s1 [2];
  int m_out [2];

  function automatic int mult(input bit is_tx, input int code);
    int rxm [5] = '{16384, 23143, 32690, 46176, 65226};   // R3
    int txm [5] = '{16384, 11599, 8211, 5813, 4115};      // R4
    if (code > 4) return 16384;                           // R5
    return is_tx ? txm[code] : rxm[code];
  endfunction

  function automatic int scale(input int x, input int m);
    longint p;
    p = (longint'(x) * m + 8192) >>> 14;
    if (p > 32767) p = 32767;                             // R8
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  function automatic int expect_out(input bit is_tx, input int x);
    int m;
    if (m_coarse != 0) begin                              // R7
      if (is_tx) m = (m_coarse & 2) ? 11599 : 16384;
      else       m = (m_coarse & 1) ? 32690 : 16384;
      return scale(x, m);
    end
    if (is_tx) begin
      if (m_fine & 8'h80) return 0;                       // R6
      return scale(x, mult(1, (m_fine >> 4) & 7));
    end
    if (m_fine & 8'h08) return 0;                         // R6
    return scale(x, mult(0, m_fine & 7));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_coarse = 0; m_fine = 0;
      for (int p = 0; p < 2; p++) begin
        m_v1[p] = 0; m_v2[p] = 0; m_s1[p] = 0; m_out[p] = 0;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        m_v2[p] = m_v1[p];
        if (m_v1[p]) m_out[p] = m_s1[p];
      end
      m_v1[0] = rx_valid_i;
      m_v1[1] = tx_valid_i;
      if (rx_valid_i) m_s1[0] = expect_out(0, int'(rx_sample_i));  // R9 old setting
      if (tx_valid_i) m_s1[1] = expect_out(1, int'(tx_sample_i));
      if (coarse_we) m_coarse = int'(coarse_wdata);                 // R10
      if (fine_we)   m_fine   = int'(fine_wdata);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rx_valid_o !== m_v2[0] || int'(rx_sample_o) != m_out[0]) begin
        errors++;
        $display("FAIL %s rx: actual v=%0b s=%0d expected v=%0b s=%0d",
                 phase, rx_valid_o, rx_sample_o, m_v2[0], m_out[0]);
      end
      checks++;
      if (tx_valid_o !== m_v2[1] || int'(tx_sample_o) != m_out[1]) begin
        errors++;
        $display("FAIL %s tx: actual v=%0b s=%0d expected v=%0b s=%0d",
                 phase, tx_valid_o, tx_sample_o, m_v2[1], m_out[1]);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cyc(input bit rv, input int rs, input bit tv, input int ts,
                     input bit cw, input int cd, input bit fw, input int fd);
    rx_valid_i = rv; rx_sample_i = 16'(rs);
    tx_valid_i = tv; tx_sample_i = 16'(ts);
    coarse_we = cw; coarse_wdata = 2'(cd);
    fine_we = fw; fine_wdata = 8'(fd);
    @(negedge clk);
    rx_valid_i = 0; tx_valid_i = 0; coarse_we = 0; fine_we = 0;
  endtask

  task automatic both(input int rs, input int ts);
    cyc(1, rs, 1, ts, 0, 0, 0, 0);
  endtask

  initial begin
    int vals [6] = '{1000, -1000, 12345, -7, 32767, -32768};
    phase = "R1";
    idle(4);
    rst_n = 1'b1;
    idle(4);

    phase = "R3";
    for (int c = 0; c < 5; c++) begin
      cyc(0, 0, 0, 0, 0, 0, 1, c | (c << 4));
      foreach (vals[k]) both(vals[k] / 4, vals[k]);
    end
    phase = "R4";
    for (int c = 0; c < 5; c++) begin
      cyc(0, 0, 0, 0, 0, 0, 1, c << 4);
      foreach (vals[k]) both(vals[k] / 3, vals[k]);
    end
    phase = "R5";
    for (int c = 5; c < 8; c++) begin
      cyc(0, 0, 0, 0, 0, 0, 1, c | (c << 4));
      foreach (vals[k]) both(vals[k], -vals[k] / 2);
    end
    phase = "R6";
    cyc(0, 0, 0, 0, 0, 0, 1, 8'h0A);
    foreach (vals[k]) both(vals[k], vals[k]);
    cyc(0, 0, 0, 0, 0, 0, 1, 8'hB1);
    foreach (vals[k]) both(vals[k], vals[k]);
    phase = "R7";
    cyc(0, 0, 0, 0, 1, 1, 1, 8'hCC);
    foreach (vals[k]) both(vals[k], vals[k]);
    cyc(0, 0, 0, 0, 1, 2, 0, 0);
    foreach (vals[k]) both(vals[k], vals[k]);
    cyc(0, 0, 0, 0, 1, 3, 0, 0);
    foreach (vals[k]) both(vals[k], vals[k]);
    phase = "R8";
    cyc(0, 0, 0, 0, 1, 0, 1, 8'h04);
    both(32767, 32767); both(-32768, -32768); both(9000, 1);
    both(-8300, -1); both(8230, 0); both(-20000, 5);
    phase = "R9";
    cyc(1, 4000, 1, 4000, 0, 0, 1, 8'h12);
    cyc(1, 4000, 1, 4000, 0, 0, 1, 8'h88);
    cyc(1, 4000, 1, 4000, 1, 1, 0, 0);
    cyc(1, 4000, 1, 4000, 1, 0, 1, 8'h33);
    both(4000, 4000);
    phase = "R2";
    cyc(1, 111, 0, 0, 0, 0, 0, 0);
    idle(3);
    cyc(0, 0, 1, -222, 0, 0, 0, 0);
    idle(1);
    cyc(1, 333, 1, 444, 0, 0, 0, 0);
    idle(5);
    phase = "R10";
    for (int n = 0; n < 400; n++) begin
      cyc($urandom_range(1, 0), $urandom_range(65535, 0) - 32768,
          $urandom_range(1, 0), $urandom_range(65535, 0) - 32768,
          ($urandom_range(7, 0) == 0), $urandom_range(3, 0),
          ($urandom_range(3, 0) == 0), $urandom_range(255, 0));
    end
    idle(4);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule